// File: doc/BRIEF.md
# Refresh-Bit Watchdog Timer

This block watches software and requests a system reset when software stops refreshing it. It has no reload value. A free-running period counter advances on an external timebase tick and starts from zero at every system reset. At each period boundary the block checks a refresh flag that software sets and that hardware clears. With the default of two 1 ms ticks per period, a period lasts about 2 ms.

The period counter runs from reset whether or not the watchdog is enabled. If a boundary passes while the watchdog is disabled and no refresh is pending, the expiry is latched. Enabling the watchdog later, without a refresh, then requests the reset straight away. Writing the refresh flag before the enable flag avoids this and guarantees at least one full period of grace.

Once the watchdog has fired, it holds its reset request until the system reset arrives. A cause flag records the event and is kept through a system reset, so software can read it afterwards. Only a power-on reset or a software clear removes it.

Top module: `wdt_refresh`

## Requirements
- R1: After power-on reset, `rd_data` reads 3'b000 and `wdt_rst` is 0.
- R2: A write with `wr_data[0]`=1 sets the enable flag, which reads back on `rd_data[0]`. A write with `wr_data[0]`=0 leaves it unchanged. Only a system or power-on reset clears it.
- R3: A write with `wr_data[1]`=1 sets the refresh flag, which reads back on `rd_data[1]`. A write with `wr_data[1]`=0 has no effect on it. Hardware clears it at every period boundary. A period boundary is a cycle with `tick`=1 in which the period counter holds PERIOD_TICKS-1.
- R4: The period counter starts at 0 at each system reset and counts `tick` pulses whether or not the watchdog is enabled. When a boundary occurs with the enable flag set and the refresh flag clear, `wdt_rst` goes to 1 at that clock edge. This holds even if the watchdog was enabled only partway through the period.
- R5: A boundary that finds the refresh flag set requests no reset and clears the refresh flag.
- R6: A boundary that finds both the enable flag and the refresh flag clear latches a pending expiry. A later write that sets the enable flag without the refresh flag raises `wdt_rst` at the clock edge that takes the write.
- R7: Writing the refresh flag clears a pending expiry. After that, enabling the watchdog requests no reset until a boundary finds the refresh flag clear.
- R8: Once `wdt_rst` is 1, it stays 1 until a system or power-on reset.
- R9: The cause flag (`rd_data[2]`) goes to 1 at the edge where `wdt_rst` rises, and a system reset leaves it unchanged. Power-on reset clears it, and so does any write with `wr_data[2]`=0. A write with `wr_data[2]`=1 has no effect on it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Power-on reset, active low, clears everything |
| rst_n | input | 1 | System reset, active low, keeps the cause flag |
| tick | input | 1 | Timebase tick, one cycle wide |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 3 | Write data: bit0 enable, bit1 refresh, bit2 cause clear-on-0 |
| rd_data | output | 3 | Read data: {cause, refresh, enable} |
| wdt_rst | output | 1 | Reset request, held until reset |

## Verification
The bench builds the block with PERIOD_TICKS=3. This gives a period length that is not a power of two and exercises the wrap compare, and every boundary is reached within a few cycles of tick pulses. With that short period, one run can cover a refreshed boundary, an unrefreshed boundary, a shortened first timeout, a latched expiry fired by a late enable, and a refresh-before-enable sequence. It can also run these across both kinds of reset, so the cause flag is seen surviving one reset and cleared by the other.

// File: rtl/wdt_refresh.sv
module wdt_refresh #(
  parameter int PERIOD_TICKS = 2
) (
  input  logic       clk,
  input  logic       por_n,
  input  logic       rst_n,
  input  logic       tick,
  input  logic       wr_en,
  input  logic [2:0] wr_data,
  output logic [2:0] rd_data,
  output logic       wdt_rst
);
  localparam int CW = (PERIOD_TICKS > 1) ? $clog2(PERIOD_TICKS) : 1;
  localparam logic [CW-1:0] LAST = CW'(PERIOD_TICKS - 1);

  logic [CW-1:0] cnt;
  logic arm, kick, pend, cause;

  wire sys_n    = rst_n & por_n;
  wire boundary = tick && (cnt == LAST);
  wire arm_nx   = arm | (wr_en & wr_data[0]);
  wire kick_wr  = wr_en & wr_data[1];
  wire kick_nx  = kick | kick_wr;
  wire expire   = arm_nx && !kick_nx && (boundary || pend);

  always_ff @(posedge clk or negedge sys_n)
    if (!sys_n)    cnt <= '0;
    else if (tick) cnt <= boundary ? '0 : cnt + 1'b1;

  always_ff @(posedge clk or negedge sys_n)
    if (!sys_n) arm <= 1'b0;
    else        arm <= arm_nx;

  always_ff @(posedge clk or negedge sys_n)
    if (!sys_n)       kick <= 1'b0;
    else if (boundary) kick <= 1'b0;
    else if (kick_wr)  kick <= 1'b1;

  always_ff @(posedge clk or negedge sys_n)
    if (!sys_n)                    pend <= 1'b0;
    else if (kick_wr)              pend <= 1'b0;
    else if (boundary && !kick_nx) pend <= 1'b1;

  always_ff @(posedge clk or negedge sys_n)
    if (!sys_n)      wdt_rst <= 1'b0;
    else if (expire) wdt_rst <= 1'b1;

  always_ff @(posedge clk or negedge por_n)
    if (!por_n)                      cause <= 1'b0;
    else if (expire)                 cause <= 1'b1;
    else if (wr_en && !wr_data[2])   cause <= 1'b0;

  assign rd_data = {cause, kick, arm};

  AST_ARM_STICKY: assert property (@(posedge clk) disable iff (!sys_n)
    arm |=> arm); // R2
  AST_FIRE_NEEDS_ARM: assert property (@(posedge clk) disable iff (!sys_n)
    $rose(wdt_rst) |-> arm); // R4
  AST_KICK_BLOCKS: assert property (@(posedge clk) disable iff (!sys_n)
    (kick && !wdt_rst) |=> !wdt_rst); // R5
  AST_RST_HOLD: assert property (@(posedge clk) disable iff (!sys_n)
    wdt_rst |=> wdt_rst); // R8
  AST_CAUSE_ON_FIRE: assert property (@(posedge clk) disable iff (!sys_n)
    $rose(wdt_rst) |-> cause); // R9
endmodule

// File: tb/wdt_refresh_bench.sv
module wdt_refresh_bench;
  logic clk = 1'b0;
  logic por_n = 1'b0, rst_n = 1'b0, tick = 1'b0, wr_en = 1'b0;
  logic [2:0] wr_data = 3'b000;
  logic [2:0] rd_data;
  logic wdt_rst;

  always #5 clk = ~clk;

  wdt_refresh #(.PERIOD_TICKS(3)) u_wdt_refresh (
    .clk(clk), .por_n(por_n), .rst_n(rst_n), .tick(tick),
    .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data), .wdt_rst(wdt_rst));

  typedef struct {
    string      tag;
    logic [2:0] rd;
    logic       rs;
  } exp_t;
  exp_t q[$];
  int n_chk = 0, n_bad = 0;
  bit done = 0;

  // driver: apply inputs for one cycle, optionally queue the result expected after the edge
  task automatic cyc(input logic w, input logic [2:0] d, input logic t,
                     input bit chk, input string tag, input logic [2:0] er, input logic ers);
    exp_t e;
    @(negedge clk);
    wr_en = w; wr_data = d; tick = t;
    if (chk) begin
      e.tag = tag; e.rd = er; e.rs = ers;
      q.push_back(e);
    end
  endtask

  task automatic reset_pulse(input bit por);
    @(negedge clk);
    wr_en = 1'b0; tick = 1'b0; wr_data = 3'b000;
    rst_n = 1'b0;
    if (por) por_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1; por_n = 1'b1;
  endtask

  // monitor: compare against the queue just after each edge
  initial begin
    exp_t e;
    forever begin
      @(posedge clk);
      #2;
      if (q.size() > 0) begin
        e = q.pop_front();
        n_chk++;
        if (rd_data !== e.rd || wdt_rst !== e.rs) begin
          n_bad++;
          $display("FAIL %s rd_data=%b exp=%b wdt_rst=%b exp=%b",
                   e.tag, rd_data, e.rd, wdt_rst, e.rs);
        end
      end
    end
  end

  initial begin
    #2000000;
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    por_n = 1'b1; rst_n = 1'b1;
    cyc(0, 3'b000, 0, 1, "R1 reset state", 3'b000, 0);

    // refreshed boundaries, then unrefreshed boundary
    cyc(1, 3'b011, 0, 1, "R2 R3 set enable and refresh", 3'b011, 0);
    cyc(1, 3'b000, 0, 1, "R2 R3 write zero ignored", 3'b011, 0);
    cyc(0, 3'b000, 1, 1, "R3 tick1", 3'b011, 0);
    cyc(0, 3'b000, 1, 1, "R3 tick2", 3'b011, 0);
    cyc(0, 3'b000, 1, 1, "R5 refreshed boundary", 3'b001, 0);
    cyc(1, 3'b010, 0, 1, "R3 refresh again", 3'b011, 0);
    cyc(0, 3'b000, 1, 0, "", 3'b000, 0);
    cyc(0, 3'b000, 1, 0, "", 3'b000, 0);
    cyc(0, 3'b000, 1, 1, "R5 second refreshed boundary", 3'b001, 0);
    cyc(0, 3'b000, 1, 0, "", 3'b000, 0);
    cyc(0, 3'b000, 1, 1, "R4 before boundary", 3'b001, 0);
    cyc(0, 3'b000, 1, 1, "R4 unrefreshed boundary fires", 3'b101, 1);
    cyc(0, 3'b000, 0, 1, "R8 hold 1", 3'b101, 1);
    cyc(0, 3'b000, 1, 1, "R8 hold 2", 3'b101, 1);
    cyc(0, 3'b000, 0, 1, "R8 hold 3", 3'b101, 1);

    reset_pulse(0);
    cyc(0, 3'b000, 0, 1, "R9 cause survives system reset", 3'b100, 0);
    cyc(1, 3'b100, 0, 1, "R9 write one ignored", 3'b100, 0);
    cyc(1, 3'b000, 0, 1, "R9 write zero clears", 3'b000, 0);

    // latched expiry while disabled
    cyc(0, 3'b000, 1, 0, "", 3'b000, 0);
    cyc(0, 3'b000, 1, 0, "", 3'b000, 0);
    cyc(0, 3'b000, 1, 1, "R6 disabled boundary no reset", 3'b000, 0);
    cyc(0, 3'b000, 0, 1, "R6 still idle", 3'b000, 0);
    cyc(1, 3'b001, 0, 1, "R6 late enable fires", 3'b101, 1);

    reset_pulse(1);
    cyc(0, 3'b000, 0, 1, "R9 power-on clears cause", 3'b000, 0);

    // short first timeout
    cyc(0, 3'b000, 1, 0, "", 3'b000, 0);
    cyc(0, 3'b000, 1, 0, "", 3'b000, 0);
    cyc(1, 3'b001, 0, 1, "R4 enable mid-period", 3'b001, 0);
    cyc(0, 3'b000, 1, 1, "R4 shortened first timeout", 3'b101, 1);

    reset_pulse(0);
    cyc(1, 3'b000, 0, 1, "R9 cleared by write after reset", 3'b000, 0);

    // refresh before enable
    cyc(0, 3'b000, 1, 0, "", 3'b000, 0);
    cyc(0, 3'b000, 1, 0, "", 3'b000, 0);
    cyc(0, 3'b000, 1, 1, "R7 pending latched", 3'b000, 0);
    cyc(1, 3'b010, 0, 1, "R7 refresh first", 3'b010, 0);
    cyc(1, 3'b011, 0, 1, "R7 enable no reset", 3'b011, 0);
    cyc(0, 3'b000, 1, 0, "", 3'b000, 0);
    cyc(0, 3'b000, 1, 0, "", 3'b000, 0);
    cyc(0, 3'b000, 1, 1, "R7 grace boundary", 3'b001, 0);
    cyc(0, 3'b000, 1, 0, "", 3'b000, 0);
    cyc(0, 3'b000, 1, 0, "", 3'b000, 0);
    cyc(0, 3'b000, 1, 1, "R7 next boundary fires", 3'b101, 1);

    reset_pulse(1);
    cyc(0, 3'b000, 0, 1, "R1 power-on reset state", 3'b000, 0);
    repeat (3) @(negedge clk);

    done = 1;
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule